// File: doc/BRIEF.md
# Smartcard UART Buffer and Status Controller

This block sits between a smartcard UART framer and a simple register bus. It keeps a small transmit queue and a small receive queue, both four bytes deep. It exposes the fill state of both queues as status bits, and it holds sticky line-error bits. It raises four interrupt sources, each with its own enable, and merges them into one interrupt line. Software writes bytes to the data register to queue them for sending. The framer takes them one at a time into its shift register. Bytes the framer receives are queued until software reads them back through the same data register.

Some status behaviours follow their own rules. The transmit-empty bit rises when the framer takes the last queued byte, not when the line goes idle. The receive-empty bit rises when software reads out the last byte. The received-data interrupt is a level compare of the receive count against a programmable threshold. A receive idle timeout counts character periods while data waits unread.

Top module: `card_uart_buffer`

## Requirements
- R1: Each queue holds 4 bytes. Its full bit is 1 exactly when 4 bytes are held. The status register (address 1) carries: bit0 rx-empty, bit1 rx-full, bit2 tx-empty, bit3 tx-full, bit4 tx-active, bit5 parity error, bit6 framing error, bit7 break error, bits[11:8] receive count and bits[15:12] transmit count.
- R2: The tx-empty bit is 1 after reset. It is set when the framer takes the last queued byte (`tx_take` with one byte held). Any write to the data register (address 0) clears it. The same last-byte event sets the transmit-empty interrupt flag (bit1 of the interrupt-status register, address 3).
- R3: The rx-empty bit is 1 after reset. It is set when software reads the last queued byte from the data register. It is cleared when a byte is accepted from the framer.
- R4: The received-data flag (interrupt-status bit0) is 1 while the receive count is greater than or equal to the threshold. The threshold is trigger code + 1, and the trigger code is bits[1:0] of the configuration register (address 4).
- R5: Writing 1 to interrupt-status bits 1 (transmit empty), 2 (transfer error) or 3 (receive timeout) clears them. Writing 1 to bit0 has no effect; that flag falls only when the receive queue drains below the threshold.
- R6: The parity, framing and break error inputs set the sticky status bits 5, 6 and 7. Writing 1 to the same bit positions of the status register clears them. Any of these errors also sets the transfer-error flag.
- R7: When configuration bits[15:8] hold a nonzero limit N, N character ticks with data held in the receive queue set the receive-timeout flag (interrupt-status bit3). No byte may arrive and no data read may occur in that span, since either one restarts the count. A limit of 0 disables the timeout.
- R8: A data-register write while the transmit queue is full is dropped. A data-register read while the receive queue is empty returns 0 and changes nothing.
- R9: A byte that arrives while the receive queue is full is discarded, and the transfer-error flag is set.
- R10: `irq` is the OR of each interrupt-status bit ANDed with the enable bit at the same position of the interrupt-enable register (address 2).
- R11: The tx-active bit is 1 while the transmit queue holds data or the framer reports `tx_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at address 0) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_take | input | 1 | Framer moves the head byte into its shift register |
| tx_busy | input | 1 | Framer shift register is sending |
| rx_byte | input | 8 | Byte from the framer |
| rx_strobe | input | 1 | rx_byte is valid this cycle |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_berr | input | 1 | Break detected with this byte |
| char_tick | input | 1 | One pulse per character period |
| irq | output | 1 | Combined interrupt |

## Verification
Assertions check on every cycle that no queue count ever goes past the depth or moves by more than one. They also check that a data write leaves tx-empty low, that rx-empty never stands beside held data, that an overflow byte always leaves the transfer-error flag set, and that the timeout never rises on an empty queue. The directed scenarios alone can show the order of transmitted and received bytes. They also cover the exact tick on which the timeout fires, the threshold for each trigger code, and the survival of the received-data flag after a write-1. The clearing of each sticky bit and the masking of `irq` by its enables are shown the same way.

// File: rtl/card_uart_pkg.sv
// Shared register addresses and bit positions for the smartcard UART buffer.
package card_uart_pkg;
    typedef enum logic [2:0] {
        ADR_DATA = 3'd0,
        ADR_STAT = 3'd1,
        ADR_IEN  = 3'd2,
        ADR_ISTS = 3'd3,
        ADR_CFG  = 3'd4
    } reg_addr_e;

    // interrupt-status bit positions
    localparam int IF_RDA  = 0;
    localparam int IF_TBE  = 1;
    localparam int IF_TERR = 2;
    localparam int IF_RTO  = 3;
    localparam int N_IRQ   = 4;

    // status bit positions
    localparam int ST_RXE  = 0;
    localparam int ST_RXF  = 1;
    localparam int ST_TXE  = 2;
    localparam int ST_TXF  = 3;
    localparam int ST_ACT  = 4;
    localparam int ST_ERR0 = 5;
    localparam int N_ERR   = 3;
endpackage

// File: rtl/cu_fifo.sv
// Small circular byte queue.
// Assumes: push when full and pop when empty are ignored here; the caller
// decides what those mean at the block edge.
module cu_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // storage write and pointer/count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((count == $past(count)) || (count == $past(count) + 1'b1)
                          || (count == $past(count) - 1'b1)));
endmodule

// File: rtl/cu_rx_timeout.sv
// Receive idle timeout: counts character ticks while data waits unread.
// Assumes: activity (byte arrival or data read) restarts the count; a
// limit of zero disables firing. fire is a one-cycle set pulse.
module cu_rx_timeout #(
    parameter int TOUT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_tick,
    input  logic              has_data,
    input  logic              activity,
    input  logic [TOUT_W-1:0] limit,
    output logic              fire
);
    logic [TOUT_W-1:0] cnt;

    assign fire = char_tick && has_data && !activity && (limit != '0)
                  && (cnt + 1'b1 == limit);

    // idle character counter with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || !has_data || activity) cnt <= '0;
        else if (char_tick && (cnt != '1))  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cu_sticky_bank.sv
// Bank of sticky flags: set by hardware, cleared by a write-1 mask.
// Assumes: a set and a clear in the same cycle leave the flag set.
module cu_sticky_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // one sticky bit, set has priority
        always_ff @(posedge clk) begin
            if (!rst_n)      q[g] <= 1'b0;
            else if (set[g]) q[g] <= 1'b1;
            else if (clr[g]) q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/card_uart_buffer.sv
// Queues, status bits and interrupt logic around a smartcard UART framer.
// Assumes: the framer asserts tx_take only while tx_valid is high and gives
// one rx_strobe per received character; bus reads are combinational.
module card_uart_buffer
    import card_uart_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BUS_W  = 16,
    parameter int TOUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [7:0]       tx_byte,
    output logic             tx_valid,
    input  logic             tx_take,
    input  logic             tx_busy,
    input  logic [7:0]       rx_byte,
    input  logic             rx_strobe,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             rx_berr,
    input  logic             char_tick,
    output logic             irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TRG_W = 2;

    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_emp_q, rx_full, rx_emp_q;
    logic [7:0] rx_head;
    logic data_wr, data_rd, stat_wr, ien_wr, ists_wr, cfg_wr;
    logic tx_push, tx_pop, rx_push, rx_pop, last_take, last_read;
    logic tx_empty_flag, rx_empty_flag;
    logic [N_IRQ-1:0] ien_q, int_flags;
    logic [N_IRQ-2:0] stk_set, stk_clr, stk_q;
    logic [N_ERR-1:0] err_set, err_clr, err_q;
    logic [TRG_W-1:0] trig_q;
    logic [TOUT_W-1:0] tout_q;
    logic rda_lvl, rto_fire, overflow;
    logic unused_wbits;

    // bus decode
    assign data_wr = bus_sel && bus_wr && (bus_addr == ADR_DATA);
    assign data_rd = bus_sel && bus_rd && (bus_addr == ADR_DATA);
    assign stat_wr = bus_sel && bus_wr && (bus_addr == ADR_STAT);
    assign ien_wr  = bus_sel && bus_wr && (bus_addr == ADR_IEN);
    assign ists_wr = bus_sel && bus_wr && (bus_addr == ADR_ISTS);
    assign cfg_wr  = bus_sel && bus_wr && (bus_addr == ADR_CFG);
    assign unused_wbits = ^bus_wdata;

    // transmit side
    assign tx_push   = data_wr;
    assign tx_pop    = tx_take && tx_valid;
    assign tx_valid  = !tx_emp_q;
    assign last_take = tx_pop && (tx_cnt == CNT_W'(1));

    cu_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wdata(bus_wdata[7:0]), .rdata(tx_byte), .count(tx_cnt),
        .full(tx_full), .empty(tx_emp_q)
    );

    // receive side
    assign rx_push   = rx_strobe && !rx_full;
    assign overflow  = rx_strobe && rx_full;
    assign rx_pop    = data_rd && !rx_emp_q;
    assign last_read = rx_pop && (rx_cnt == CNT_W'(1));

    cu_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata(rx_byte), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_emp_q)
    );

    // tx-empty status: set on last byte into shift register, cleared by data write
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_empty_flag <= 1'b1;
        else if (data_wr)   tx_empty_flag <= 1'b0;
        else if (last_take) tx_empty_flag <= 1'b1;
    end

    // rx-empty status: set by read of last byte, cleared by a new byte
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_empty_flag <= 1'b1;
        else if (rx_push)   rx_empty_flag <= 1'b0;
        else if (last_read) rx_empty_flag <= 1'b1;
    end

    // enable and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            trig_q <= '0;
            tout_q <= '0;
        end else begin
            if (ien_wr) ien_q <= bus_wdata[N_IRQ-1:0];
            if (cfg_wr) begin
                trig_q <= bus_wdata[TRG_W-1:0];
                tout_q <= bus_wdata[8 +: TOUT_W];
            end
        end
    end

    cu_rx_timeout #(.TOUT_W(TOUT_W)) u_rto (
        .clk(clk), .rst_n(rst_n), .char_tick(char_tick),
        .has_data(!rx_emp_q), .activity(rx_strobe || data_rd),
        .limit(tout_q), .fire(rto_fire)
    );

    // sticky interrupt flags (tbe, terr, rto) and error flags
    assign stk_set = {rto_fire,
                      overflow || (rx_strobe && (rx_perr || rx_ferr || rx_berr)),
                      last_take && !data_wr};
    assign stk_clr = ists_wr ? bus_wdata[N_IRQ-1:1] : '0;
    assign err_set = rx_strobe ? {rx_berr, rx_ferr, rx_perr} : '0;
    assign err_clr = stat_wr ? bus_wdata[ST_ERR0 +: N_ERR] : '0;

    cu_sticky_bank #(.N(N_IRQ-1)) u_iflags (
        .clk(clk), .rst_n(rst_n), .set(stk_set), .clr(stk_clr), .q(stk_q)
    );
    cu_sticky_bank #(.N(N_ERR)) u_eflags (
        .clk(clk), .rst_n(rst_n), .set(err_set), .clr(err_clr), .q(err_q)
    );

    assign rda_lvl   = ({1'b0, rx_cnt} >= ({{(CNT_W+1-TRG_W){1'b0}}, trig_q} + 1'b1));
    assign int_flags = {stk_q, rda_lvl};
    assign irq       = |(int_flags & ien_q);

    // read-data mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_DATA: bus_rdata[7:0] = rx_emp_q ? 8'h00 : rx_head;
            ADR_STAT: begin
                bus_rdata[ST_RXE] = rx_empty_flag;
                bus_rdata[ST_RXF] = rx_full;
                bus_rdata[ST_TXE] = tx_empty_flag;
                bus_rdata[ST_TXF] = tx_full;
                bus_rdata[ST_ACT] = !tx_emp_q || tx_busy;
                bus_rdata[ST_ERR0 +: N_ERR] = err_q;
                bus_rdata[8 +: CNT_W]  = rx_cnt;
                bus_rdata[12 +: CNT_W] = tx_cnt;
            end
            ADR_IEN:  bus_rdata[N_IRQ-1:0] = ien_q;
            ADR_ISTS: bus_rdata[N_IRQ-1:0] = int_flags;
            ADR_CFG: begin
                bus_rdata[TRG_W-1:0]  = trig_q;
                bus_rdata[8 +: TOUT_W] = tout_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assert_txempty_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !tx_empty_flag);
    assert_rxempty_nodata_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty_flag |-> (rx_cnt == '0));
    assert_overflow_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> int_flags[IF_TERR]);
    assert_rto_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(int_flags[IF_RTO])) |-> ($past(rx_cnt) != '0));
endmodule

// File: tb/card_uart_buffer_tb_top.sv
module card_uart_buffer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0] tx_byte;
    logic tx_valid, irq;
    logic tx_take = 0, tx_busy = 0;
    logic [7:0] rx_byte = '0;
    logic rx_strobe = 0, rx_perr = 0, rx_ferr = 0, rx_berr = 0, char_tick = 0;
    int total = 0, bad = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;

    card_uart_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_take(tx_take), .tx_busy(tx_busy), .rx_byte(rx_byte),
        .rx_strobe(rx_strobe), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_berr(rx_berr), .char_tick(char_tick), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk); bus_sel = 0; bus_rd = 0;
    endtask

    task automatic rx_in(input logic [7:0] b, input logic [2:0] e);
        @(negedge clk); rx_strobe = 1; rx_byte = b; {rx_berr, rx_ferr, rx_perr} = e;
        @(negedge clk); rx_strobe = 0; {rx_berr, rx_ferr, rx_perr} = '0;
    endtask

    task automatic take();
        @(negedge clk); tx_take = 1;
        @(negedge clk); tx_take = 0;
    endtask

    task automatic tick();
        @(negedge clk); char_tick = 1;
        @(negedge clk); char_tick = 0;
    endtask

    task automatic t_reset();
        rd(3'd1, rv); check("R1 R2 R3 reset status", rv, 16'h0005);
        rd(3'd3, rv); check("R10 reset int status", rv, 16'h0000);
        check("R10 reset irq", {15'd0, irq}, 16'h0);
    endtask

    task automatic t_tx();
        for (int i = 0; i < 5; i++) wr(3'd0, 16'(8'hA0 + i));
        rd(3'd1, rv); check("R1 R8 tx full, count 4, 5th dropped", rv & 16'hF01C, 16'h4018);
        check("R1 head byte", {8'd0, tx_byte}, 16'h00A0);
        for (int i = 0; i < 3; i++) take();
        rd(3'd1, rv); check("R2 tx-empty low with one byte left", rv & 16'h0004, 16'h0);
        check("R8 dropped byte not queued", {8'd0, tx_byte}, 16'h00A3);
        take();
        rd(3'd1, rv); check("R2 R11 tx-empty set, idle", rv & 16'hF01C, 16'h0004);
        rd(3'd3, rv); check("R2 tbe flag set", rv & 16'h2, 16'h2);
        tx_busy = 1;
        rd(3'd1, rv); check("R11 active while framer busy", rv & 16'h10, 16'h10);
        tx_busy = 0;
        wr(3'd3, 16'h0002);
        rd(3'd3, rv); check("R5 tbe cleared by write-1", rv & 16'h2, 16'h0);
        wr(3'd0, 16'h0055);
        rd(3'd1, rv); check("R2 data write clears tx-empty", rv & 16'h4, 16'h0);
        take();
        wr(3'd3, 16'h0002);
    endtask

    task automatic t_rx();
        wr(3'd4, 16'h0001);
        rx_in(8'h11, 3'b0);
        rd(3'd1, rv); check("R3 rx-empty cleared by byte", rv & 16'h1, 16'h0);
        rd(3'd3, rv); check("R4 below threshold 2", rv & 16'h1, 16'h0);
        rx_in(8'h22, 3'b0);
        rd(3'd3, rv); check("R4 at threshold 2", rv & 16'h1, 16'h1);
        wr(3'd3, 16'h0001);
        rd(3'd3, rv); check("R5 rda survives write-1", rv & 16'h1, 16'h1);
        wr(3'd4, 16'h0002);
        rd(3'd3, rv); check("R4 below threshold 3", rv & 16'h1, 16'h0);
        wr(3'd4, 16'h0001);
        rd(3'd0, rv); check("R3 first byte order", rv, 16'h0011);
        rd(3'd3, rv); check("R4 drained below threshold", rv & 16'h1, 16'h0);
        rd(3'd1, rv); check("R3 rx-empty low, one held", rv & 16'h1, 16'h0);
        rd(3'd0, rv); check("R3 second byte", rv, 16'h0022);
        rd(3'd1, rv); check("R3 rx-empty set by last read", rv & 16'h0F01, 16'h0001);
        rd(3'd0, rv); check("R8 empty read returns 0", rv, 16'h0000);
        rd(3'd1, rv); check("R8 empty read leaves count", rv & 16'h0F01, 16'h0001);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 5; i++) rx_in(8'h30 + 8'(i), 3'b0);
        rd(3'd1, rv); check("R1 R9 rx full count 4", rv & 16'h0F03, 16'h0402);
        rd(3'd3, rv); check("R9 terr set on overflow", rv & 16'h4, 16'h4);
        wr(3'd3, 16'h0004);
        rd(3'd3, rv); check("R5 terr cleared", rv & 16'h4, 16'h0);
        for (int i = 0; i < 4; i++) begin
            rd(3'd0, rv); check("R9 stored bytes intact", rv, 16'(8'h30 + i));
        end
    endtask

    task automatic t_errors();
        rx_in(8'h01, 3'b001);
        rx_in(8'h02, 3'b010);
        rx_in(8'h03, 3'b100);
        rd(3'd1, rv); check("R6 all error bits set", rv & 16'h00E0, 16'h00E0);
        rd(3'd3, rv); check("R6 error sets terr", rv & 16'h4, 16'h4);
        wr(3'd1, 16'h0020);
        rd(3'd1, rv); check("R6 parity cleared alone", rv & 16'h00E0, 16'h00C0);
        wr(3'd1, 16'h00C0);
        rd(3'd1, rv); check("R6 framing/break cleared", rv & 16'h00E0, 16'h0000);
        wr(3'd3, 16'h000E);
        for (int i = 0; i < 3; i++) rd(3'd0, rv);
    endtask

    task automatic t_timeout();
        wr(3'd4, 16'h0300);
        rx_in(8'h44, 3'b0);
        tick(); tick();
        rd(3'd3, rv); check("R7 no timeout after 2 ticks", rv & 16'h8, 16'h0);
        tick();
        rd(3'd3, rv); check("R7 timeout after 3 ticks", rv & 16'h8, 16'h8);
        wr(3'd3, 16'h0008);
        rd(3'd3, rv); check("R5 rto cleared", rv & 16'h8, 16'h0);
        rd(3'd0, rv);
        tick(); tick(); tick(); tick();
        rd(3'd3, rv); check("R7 no timeout when empty", rv & 16'h8, 16'h0);
        wr(3'd4, 16'h0000);
        rx_in(8'h45, 3'b0);
        for (int i = 0; i < 6; i++) tick();
        rd(3'd3, rv); check("R7 limit 0 disables", rv & 16'h8, 16'h0);
        rd(3'd0, rv);
    endtask

    task automatic t_irq();
        wr(3'd0, 16'h0077); take();
        wr(3'd2, 16'h0000);
        #1 check("R10 irq masked", {15'd0, irq}, 16'h0);
        wr(3'd2, 16'h0002);
        #1 check("R10 irq from tbe", {15'd0, irq}, 16'h1);
        wr(3'd2, 16'h0001);
        #1 check("R10 rda enabled, queue empty", {15'd0, irq}, 16'h0);
        rx_in(8'h99, 3'b0);
        #1 check("R10 irq from rda", {15'd0, irq}, 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_tx();
        t_rx();
        t_overflow();
        t_errors();
        t_timeout();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule